// File: doc/BRIEF.md
# Pin Interrupt Sense Unit

This unit watches eight external interrupt pins and one non-maskable line on behalf of a parent interrupt controller. Each of the eight pins is first brought into the clock domain through a two-flop synchroniser. It is then judged against a sense mode that software picks for it: low level, falling edge, rising edge or any edge. A detected event is held in a per-pin pending state. While that state is held, the pin's request toward the parent stays high. The request is always an active-high level, whatever the pin's sense. The non-maskable line is synchronised and forwarded as a plain level.

Software uses a small 32-bit register bus with a combinational read path. One register selects the sense modes. The other shows the pending bits and clears them: a pending bit is cleared by writing 0 to it, and writing 1 leaves it as it is. Masking is done by the parent, so there is none here.

Each pin has a two-state machine. In `ST_IDLE` the pin has nothing pending. The transition *capture* (an event is seen) moves it to `ST_PEND`. In `ST_PEND` the request is raised. The transition *release* (a clear write arrives and no event is seen in that cycle) moves it back to `ST_IDLE`. In every other case the pin stays in its current state.

Top module: `pinsense_unit`

## Requirements
- R1: After reset all pending bits are 0, all sense fields are 0 and every `irq_req` bit is low.
- R2: A pin change reaches the pending state on the third rising clock edge after it is applied. After two edges it has no effect yet.
- R3: The sense register is at byte offset 0x14 and holds a 2-bit field for pin i at bits [2i+1:2i]. The encoding is 0 = low level, 1 = falling edge, 2 = rising edge, 3 = any edge. Bits 31:16 read as 0, and a new mode takes effect for later inputs.
- R4: In rising, falling and any-edge modes, a matching transition of the synchronised pin sets the pending bit, and the bit stays set after the pin returns. A transition that does not match leaves the bit clear.
- R5: In low-level mode the pending bit sets while the pin is low. A clear write has no effect while the pin is still low. Once the pin is high, a clear write clears the bit.
- R6: The status register is at byte offset 0x10, with pin i's pending bit at bit i. Writing a 0 to a bit clears it, and writing a 1 leaves it unchanged.
- R7: If an event is detected in the same cycle as a clear write to that bit, the event wins and the bit stays set. Other bits covered by the same write are still cleared.
- R8: `irq_req[i]` is high exactly when pin i's pending bit reads as 1.
- R9: `nmi_req` follows `nmi_in` after two rising clock edges and is not latched.
- R10: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | External interrupt pins, asynchronous |
| nmi_in | input | 1 | Non-maskable interrupt line, asynchronous, active high |
| reg_addr | input | 8 | Register byte offset |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | output | 8 | Per-pin level request to the parent controller |
| nmi_req | output | 1 | Synchronised non-maskable request |

## Verification
The bench sends a clear write in the very cycle that a rising edge is detected. A design that lets the clear win would lose that interrupt. The bench also clears a pin in low-level mode while the pin is still held low; a design without level behaviour would drop a request that is still active. It writes all ones to the status register and checks that the pending bits survive, which catches an inverted clear polarity. It checks the synchroniser latency one cycle early and then on time, which catches a missing or extra stage. It changes a sense field and writes to an unmapped offset, which would show up a field that is misplaced or aliased.

// File: rtl/pinsense_pkg.sv
package pinsense_pkg;

    // Register byte offsets decoded by the bus path
    localparam logic [31:0] STATUS_OFS = 32'h0000_0010;
    localparam logic [31:0] SENSE_OFS  = 32'h0000_0014;

    // Per-pin sense selection, value is the field encoding
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_ANY  = 2'd3
    } sense_t;

    // Per-pin pending state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pend_state_t;

endpackage

// File: rtl/pinsense_sync.sv
module pinsense_sync #(
    parameter int   WIDTH   = 8,
    parameter int   STAGES  = 2,
    parameter logic RST_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_BIT}};

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VEC;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VEC;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pinsense_detect.sv
module pinsense_detect
    import pinsense_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_t mode,
    input  logic   clr,
    output logic   req
);
    logic        prev_q;
    logic        rise;
    logic        fall;
    logic        hit;
    pend_state_t state_q;
    pend_state_t state_d;

    // Previous synchronised level for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= pin_s;
    end

    assign rise = pin_s & ~prev_q;
    assign fall = ~pin_s & prev_q;

    always_comb begin
        unique case (mode)
            SENSE_LOW:  hit = ~pin_s;
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            SENSE_ANY:  hit = rise | fall;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: capture on event, release on clear unless an event collides
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit)         state_d = ST_PEND;
            ST_PEND: if (clr && !hit) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req = (state_q == ST_PEND);
    end
endmodule

// File: rtl/pinsense_regs.sv
module pinsense_regs
    import pinsense_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    localparam int FIELD_W = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] status,
    output logic [FIELD_W-1:0]  sense_vec,
    output logic [NUM_PINS-1:0] clr,
    output logic [DATA_W-1:0]   rdata
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(SENSE_OFS);

    logic                hit_status;
    logic                hit_sense;
    logic [FIELD_W-1:0]  sense_q;

    assign hit_status = (addr == A_STATUS);
    assign hit_sense  = (addr == A_SENSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  sense_q <= '0;
        else if (wr_en && hit_sense) sense_q <= wdata[FIELD_W-1:0];
    end

    assign sense_vec = sense_q;

    // Zero-written bits request a clear
    assign clr = (wr_en && hit_status) ? ~wdata[NUM_PINS-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (hit_status)     rdata[NUM_PINS-1:0] = status;
        else if (hit_sense) rdata[FIELD_W-1:0]  = sense_q;
    end

    generate
        if (FIELD_W < DATA_W) begin : g_spare
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata[DATA_W-1:FIELD_W];
        end
    endgenerate
endmodule

// File: rtl/pinsense_unit.sv
module pinsense_unit
    import pinsense_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                nmi_in,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0] irq_req,
    output logic                nmi_req
);
    localparam int FIELD_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] clr;
    logic [FIELD_W-1:0]  sense_vec;
    logic [NUM_PINS-1:0] req;

    pinsense_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_s)
    );

    pinsense_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .async_in(nmi_in), .sync_out(nmi_req)
    );

    pinsense_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr_en), .wdata(reg_wdata),
        .status(req), .sense_vec(sense_vec), .clr(clr), .rdata(reg_rdata)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            pinsense_detect #(.IDLE_LVL(1'b1)) u_det (
                .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]),
                .mode(sense_t'(sense_vec[2*i +: 2])), .clr(clr[i]), .req(req[i])
            );
        end
    endgenerate

    assign irq_req = req;
endmodule

// File: rtl/pinsense_checker.sv
module pinsense_checker
    import pinsense_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] irq_req,
    input logic                nmi_in,
    input logic                nmi_req,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr_en,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata
);
    localparam int FIELD_W = 2 * NUM_PINS;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(SENSE_OFS);

    logic [1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              seen_q <= '0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_req == '0));

    p_status_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STATUS) |-> (reg_rdata == DATA_W'(irq_req)));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != A_STATUS && reg_addr != A_SENSE) |-> (reg_rdata == '0));

    p_nmi_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 2'd2) |-> (nmi_req == $past(nmi_in, 2)));

    generate
        if (FIELD_W < DATA_W) begin : g_hi
            p_sense_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_addr == A_SENSE) |-> (reg_rdata[DATA_W-1:FIELD_W] == '0));
        end
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_fall
            p_fall_by_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(irq_req[i]) |->
                    $past(reg_wr_en && (reg_addr == A_STATUS) && !reg_wdata[i]));
        end
    endgenerate
endmodule

bind pinsense_unit pinsense_checker #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_in(nmi_in), .nmi_req(nmi_req),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/test_pinsense_unit.sv
`timescale 1ns/100ps
module test_pinsense_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = 8'hFF;
    logic        nmi_in = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_req;
    logic        nmi_req;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Scoreboard queues: kind 0 = irq_req, 1 = reg_rdata, 2 = nmi_req
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pinsense_unit i_pinsense_unit (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .nmi_in(nmi_in),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .nmi_req(nmi_req)
    );

    // Monitor: compares pending expectations at each falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (kind_q.size() > 0) begin
                int          k;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                case (k)
                    0:       a = {24'h0, irq_req};
                    1:       a = reg_rdata;
                    default: a = {31'h0, nmi_req};
                endcase
                compared++;
                if (a !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic expect_item(input int k, input logic [31:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        step();
        reg_wr_en = 1'b0;
    endtask

    initial begin
        steps(4);
        rst_n = 1'b1;
        step();
        reg_addr = 8'h10;
        expect_item(0, 32'h0, "R1 irq_req after reset");
        expect_item(1, 32'h0, "R1 status after reset");
        step();
        reg_addr = 8'h14;
        expect_item(1, 32'h0, "R1 sense after reset");
        step();

        // pin0 low, pin1 fall, pin2 rise, pin3 any, pins4-7 rise
        wr(8'h14, 32'hFFFF_AAE4);
        reg_addr = 8'h14;
        expect_item(1, 32'h0000_AAE4, "R3 sense readback, upper bits zero");
        step();

        pin_in[2] = 1'b0;
        steps(2);
        expect_item(0, 32'h0, "R4 falling edge ignored in rise mode");
        step();
        pin_in[2] = 1'b1;
        step();
        expect_item(0, 32'h0, "R2 no effect after two edges");
        step();
        expect_item(0, 32'h04, "R4 rising edge latched on third edge");
        step();

        pin_in[1] = 1'b0;
        steps(2);
        expect_item(0, 32'h06, "R4 falling edge latched");
        step();
        pin_in[1] = 1'b1;
        steps(3);
        expect_item(0, 32'h06, "R4 bit stays set after pin returns");
        step();

        pin_in[3] = 1'b0;
        steps(2);
        expect_item(0, 32'h0E, "R4 any-edge mode on fall");
        step();
        wr(8'h10, 32'hFFFF_FFF7);
        expect_item(0, 32'h06, "R6 zero bit clears pin3 only");
        pin_in[3] = 1'b1;
        steps(2);
        expect_item(0, 32'h0E, "R4 any-edge mode on rise");
        step();
        wr(8'h10, 32'hFFFF_FFFF);
        expect_item(0, 32'h0E, "R6 ones leave bits unchanged");
        reg_addr = 8'h10;
        expect_item(1, 32'h0E, "R8 status read matches irq_req");
        step();
        wr(8'h10, 32'h0);
        expect_item(0, 32'h0, "R6 write zero clears all");
        step();

        pin_in[0] = 1'b0;
        steps(2);
        expect_item(0, 32'h01, "R5 low level sets");
        step();
        wr(8'h10, 32'h0);
        expect_item(0, 32'h01, "R5 clear ignored while pin low");
        step();
        expect_item(0, 32'h01, "R5 still set next cycle");
        pin_in[0] = 1'b1;
        steps(3);
        wr(8'h10, 32'h0);
        expect_item(0, 32'h0, "R5 clear works once pin high");
        step();

        // Collision: pin2 pending, pin4 rising edge detected in the clear cycle
        pin_in[2] = 1'b0;
        steps(3);
        pin_in[2] = 1'b1;
        steps(3);
        expect_item(0, 32'h04, "R7 setup pin2 pending");
        pin_in[4] = 1'b0;
        steps(3);
        pin_in[4] = 1'b1;
        steps(2);
        wr(8'h10, 32'h0);
        expect_item(0, 32'h10, "R7 edge beats clear, pin2 cleared");
        step();
        wr(8'h10, 32'h0);
        expect_item(0, 32'h0, "R7 later clear removes pin4");
        step();

        // pin5 to low-level mode
        wr(8'h14, 32'h0000_A2E4);
        expect_item(0, 32'h0, "R3 mode change alone sets nothing");
        pin_in[5] = 1'b0;
        steps(2);
        expect_item(0, 32'h20, "R3 new low-level mode on pin5");
        step();
        pin_in[5] = 1'b1;
        steps(3);
        wr(8'h10, 32'h0);
        expect_item(0, 32'h0, "R6 pin5 cleared");
        step();

        nmi_in = 1'b1;
        expect_item(2, 32'h0, "R9 nmi not yet after one edge");
        step();
        expect_item(2, 32'h1, "R9 nmi after two edges");
        step();
        nmi_in = 1'b0;
        step();
        expect_item(2, 32'h0, "R9 nmi follows low, not latched");
        expect_item(0, 32'h0, "R9 nmi leaves irq_req alone");
        step();

        wr(8'h18, 32'hFFFF_FFFF);
        reg_addr = 8'h14;
        expect_item(1, 32'h0000_A2E4, "R10 unmapped write leaves sense");
        step();
        reg_addr = 8'h18;
        expect_item(1, 32'h0, "R10 unmapped read zero");
        expect_item(0, 32'h0, "R10 unmapped write sets nothing");
        step();
        reg_addr = 8'h10;
        expect_item(1, 32'h0, "R10 status still zero");
        steps(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule